// File: doc/BRIEF.md
# Interprocessor Mailbox With Interrupts

This block is a one-way message channel between two processors. A sending agent writes 32-bit words into a small first-in first-out queue. The agent that owns the mailbox reads them back in the same order. Each side has its own access channel, so a write and a read can land in the same clock cycle. Three registers sit behind a 2-bit address: a data register (0), a status register (1) and a configuration register (2). A write to the status register or to address 3 has no effect.

The configuration register holds three interrupt enables, three read-only pending causes, a clear control that empties the queue, and three sticky error flags. One interrupt output is the OR of each pending cause gated by its enable. It is computed from current state, so it falls as soon as the cause goes away, with no acknowledge. The "opposite mailbox empty" cause comes from an input, which carries the empty status of the mailbox running in the other direction. Data reads return their word on `rd_data` in the same cycle as `rd_en`.

Top module: `mbox_top`

## Requirements
- R1: Words written to the data register are returned to owner reads in write order. The queue holds up to DEPTH (default 8) words of 32 bits.
- R2: The status register reads bit 31 = 1 when the queue is full and bit 30 = 1 when it is empty. All other status bits read zero.
- R3: A data write when the queue is full, judged on the occupancy before that cycle, is dropped and sets configuration bit 9.
- R4: An owner read of the data register while the queue is empty returns zero and sets configuration bit 10.
- R5: A data read by an agent whose `rd_agent` differs from OWNER_ID returns zero, does not remove a word and sets configuration bit 8.
- R6: Error bits 8–10 stay set through all other traffic. Any write to the configuration register clears them, unless a new error occurs in that same cycle.
- R7: Configuration bits 2:0 are writable enables for has-data, has-space and opposite-empty. Bits 6:4 read the matching pending causes: queue not empty, queue not full, `opp_empty` high. Bit 7 and bits 31:11 read zero, and writes to bits 31:4 have no effect.
- R8: `irq` is high exactly when some pending cause (bits 6:4) is set together with its enable (bits 2:0). It follows the causes with no acknowledge.
- R9: Writing configuration bit 3 = 1 empties the queue at that clock edge. While bit 3 stays 1, the queue stays empty and data writes are dropped. Writing bit 3 = 0 resumes normal operation.
- R10: A data write and an owner data read in the same cycle on a queue that is neither full nor empty both take effect, and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe from the sender channel |
| wr_addr | input | 2 | Write register select: 0 data, 1 status, 2 configuration |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe from the receiver channel |
| rd_addr | input | 2 | Read register select: 0 data, 1 status, 2 configuration |
| rd_agent | input | AGENT_W | Identity of the reading agent |
| rd_data | output | 32 | Read data, valid in the cycle of `rd_en` |
| opp_empty | input | 1 | Empty flag of the mailbox in the opposite direction |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that each strobe lasts exactly one cycle per access. They also assume that `rd_addr`, `wr_addr` and `rd_agent` are stable while their strobe is high, and that the configuration clear is never written in the same cycle as an owner data read of a non-empty queue. The bench drives every input once per cycle on the falling edge and holds it for the whole cycle. It never combines a clear with a pop, and it keeps a reference queue that mirrors the full-before-pop rule. Together these ensure that overflow, underflow and non-owner cases arise only where the scoreboard expects them.

// File: rtl/mbox_pkg.sv
// Package: shared register selects and configuration bit positions for the
// mailbox. Assumes a 32-bit register file behind a 2-bit address.
package mbox_pkg;
    localparam int REG_W = 32;
    localparam int N_CAUSE = 3;
    localparam int N_ERR = 3;

    typedef enum logic [1:0] {
        SEL_DATA   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_CFG    = 2'd2,
        SEL_RSVD   = 2'd3
    } reg_sel_e;

    localparam int CFG_CLR_BIT  = 3;
    localparam int CFG_PEND_LSB = 4;
    localparam int CFG_ERR_LSB  = 8;
    localparam int ST_FULL_BIT  = 31;
    localparam int ST_EMPTY_BIT = 30;

    // error vector index: 0 non-owner read, 1 overflow, 2 underflow
    localparam int ERR_NOWN = 0;
    localparam int ERR_OVF  = 1;
    localparam int ERR_UND  = 2;
endpackage

// File: rtl/mbox_queue.sv
// Module: circular word queue with occupancy count.
// Assumes the caller only asserts push when not full and pop when not
// empty; the guards here are a second line of defence. Flush has priority
// over push and pop and returns the queue to its reset state.
module mbox_queue #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic                           pop,
    input  logic                           flush,
    input  logic [W-1:0]                   wdata,
    output logic [W-1:0]                   head,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           full,
    output logic                           empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    // qualify requests against the current occupancy and flush
    always_comb begin
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
    end

    assign full  = (count == CAP);
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    // storage write, no reset needed on the data array
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mbox_ctrl.sv
// Module: access decode, configuration register, sticky errors and
// interrupt generation. Assumes single-cycle strobes on both channels and
// queue full/empty flags that reflect the state before the current edge.
module mbox_ctrl
    import mbox_pkg::*;
#(
    parameter int                AGENT_W  = 2,
    parameter logic [AGENT_W-1:0] OWNER_ID = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [3:0]         wr_ctl,
    input  logic               rd_en,
    input  logic [1:0]         rd_addr,
    input  logic [AGENT_W-1:0] rd_agent,
    input  logic               q_full,
    input  logic               q_empty,
    input  logic               opp_empty,
    output logic               push,
    output logic               pop,
    output logic               flush,
    output logic [REG_W-1:0]   cfg_word,
    output logic               irq
);
    logic               data_wr, data_rd, cfg_wr, is_owner;
    logic [N_CAUSE-1:0] en_q, pend, hit;
    logic               clr_q;
    logic [N_ERR-1:0]   err_q, err_evt;

    // decode accesses from the two channels
    always_comb begin
        data_wr  = wr_en && (wr_addr == SEL_DATA);
        cfg_wr   = wr_en && (wr_addr == SEL_CFG);
        data_rd  = rd_en && (rd_addr == SEL_DATA);
        is_owner = (rd_agent == OWNER_ID);
    end

    // queue control and error events
    always_comb begin
        push              = data_wr && !q_full && !clr_q;
        pop               = data_rd && is_owner && !q_empty;
        flush             = clr_q || (cfg_wr && wr_ctl[CFG_CLR_BIT]);
        err_evt           = '0;
        err_evt[ERR_NOWN] = data_rd && !is_owner;
        err_evt[ERR_OVF]  = data_wr && q_full && !clr_q;
        err_evt[ERR_UND]  = data_rd && is_owner && q_empty;
    end

    // enables and clear control, written as one register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            clr_q <= 1'b0;
        end else if (cfg_wr) begin
            en_q  <= wr_ctl[N_CAUSE-1:0];
            clr_q <= wr_ctl[CFG_CLR_BIT];
        end
    end

    // sticky error flags, cleared by a configuration write
    always_ff @(posedge clk) begin
        if (!rst_n)      err_q <= '0;
        else if (cfg_wr) err_q <= err_evt;
        else             err_q <= err_q | err_evt;
    end

    // pending causes: has data, has space, opposite empty
    assign pend = {opp_empty, !q_full, !q_empty};

    // one gate per cause, then reduce
    for (genvar c = 0; c < N_CAUSE; c++) begin : g_cause
        assign hit[c] = pend[c] && en_q[c];
    end
    assign irq = |hit;

    // assemble the readable configuration word
    always_comb begin
        cfg_word                               = '0;
        cfg_word[N_CAUSE-1:0]                  = en_q;
        cfg_word[CFG_CLR_BIT]                  = clr_q;
        cfg_word[CFG_PEND_LSB +: N_CAUSE]      = pend;
        cfg_word[CFG_ERR_LSB +: N_ERR]         = err_q;
    end
endmodule

// File: rtl/mbox_top.sv
// Module: one-way mailbox top. Joins the queue and the controller and
// multiplexes read data. Assumes the reader samples rd_data in the same
// cycle as rd_en; reads of status and configuration have no side effect.
module mbox_top
    import mbox_pkg::*;
#(
    parameter int                 DEPTH    = 8,
    parameter int                 AGENT_W  = 2,
    parameter logic [AGENT_W-1:0] OWNER_ID = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               rd_en,
    input  logic [1:0]         rd_addr,
    input  logic [AGENT_W-1:0] rd_agent,
    output logic [REG_W-1:0]   rd_data,
    input  logic               opp_empty,
    output logic               irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              push, pop, flush, q_full, q_empty;
    logic [REG_W-1:0]  head, cfg_word;
    logic [CNT_W-1:0]  q_count;

    mbox_queue #(.W(REG_W), .DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .flush (flush),
        .wdata (wr_data),
        .head  (head),
        .count (q_count),
        .full  (q_full),
        .empty (q_empty)
    );

    mbox_ctrl #(.AGENT_W(AGENT_W), .OWNER_ID(OWNER_ID)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_ctl    (wr_data[3:0]),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_agent  (rd_agent),
        .q_full    (q_full),
        .q_empty   (q_empty),
        .opp_empty (opp_empty),
        .push      (push),
        .pop       (pop),
        .flush     (flush),
        .cfg_word  (cfg_word),
        .irq       (irq)
    );

    // read data mux; data only when a word is actually removed
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (rd_addr)
                SEL_DATA:   rd_data = pop ? head : '0;
                SEL_STATUS: begin
                    rd_data[ST_FULL_BIT]  = q_full;
                    rd_data[ST_EMPTY_BIT] = q_empty;
                end
                SEL_CFG:    rd_data = cfg_word;
                default:    rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/mbox_checker.sv
// Module: property checker for mbox_top, attached by bind. Assumes the
// default register selects of mbox_pkg and observes the queue occupancy.
module mbox_checker
    import mbox_pkg::*;
#(
    parameter int                 DEPTH    = 8,
    parameter int                 AGENT_W  = 2,
    parameter logic [AGENT_W-1:0] OWNER_ID = 1,
    parameter int                 CNT_W    = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [1:0]         wr_addr,
    input logic               rd_en,
    input logic [1:0]         rd_addr,
    input logic [AGENT_W-1:0] rd_agent,
    input logic [REG_W-1:0]   rd_data,
    input logic               irq,
    input logic [CNT_W-1:0]   q_count,
    input logic [2:0]         en_bits,
    input logic               clr_bit,
    input logic [2:0]         err_bits
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

    logic dwr, drd, own_rd, cwr;
    assign dwr    = wr_en && (wr_addr == SEL_DATA);
    assign cwr    = wr_en && (wr_addr == SEL_CFG);
    assign drd    = rd_en && (rd_addr == SEL_DATA);
    assign own_rd = drd && (rd_agent == OWNER_ID);

    assert_fifo_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CAP);

    assert_status_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == SEL_STATUS) |->
            (rd_data[31] == (q_count == CAP)) && (rd_data[30] == (q_count == '0)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && q_count == CAP && !own_rd) |=> (q_count == CAP) && err_bits[1]);

    assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (drd && q_count == '0) |-> (rd_data == '0));

    assert_underflow_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (own_rd && q_count == '0) |=> err_bits[2]);

    assert_nonowner_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (drd && !own_rd && !wr_en) |=> ($stable(q_count) && err_bits[0]));

    assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cwr && !rd_en) |=> (err_bits == 3'b000));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_bits[0] && !cwr) |=> err_bits[0]);

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_bits == 3'b000) |-> !irq);

    assert_clear_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_bit |-> (q_count == '0));

    assert_concurrent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && own_rd && q_count != '0 && q_count != CAP && !clr_bit) |=> $stable(q_count));
endmodule

bind mbox_top mbox_checker #(
    .DEPTH    (DEPTH),
    .AGENT_W  (AGENT_W),
    .OWNER_ID (OWNER_ID)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_agent (rd_agent),
    .rd_data  (rd_data),
    .irq      (irq),
    .q_count  (q_count),
    .en_bits  (cfg_word[2:0]),
    .clr_bit  (cfg_word[3]),
    .err_bits (cfg_word[10:8])
);

// File: tb/sim_mbox_top.sv
`timescale 1ns/1ps
// Bench: scoreboard for mbox_top. The driver updates a reference queue and
// pushes expected read words; a monitor pops and compares them each cycle.
module sim_mbox_top;
    localparam int DEPTH = 8;
    localparam logic [1:0] OWNER = 2'd1;
    localparam logic [1:0] OTHER = 2'd2;
    localparam logic [1:0] A_DATA = 2'd0, A_STAT = 2'd1, A_CFG = 2'd2;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, opp_empty = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0, rd_agent = OWNER;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] mq[$];
    bit          mclr = 0;
    logic [31:0] exp_data[$];
    string       exp_tag[$];

    always #2 clk = ~clk;

    mbox_top #(.DEPTH(DEPTH), .AGENT_W(2), .OWNER_ID(OWNER)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_agent(rd_agent), .rd_data(rd_data), .opp_empty(opp_empty), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] v = '0;
        v[31] = (mq.size() == DEPTH);
        v[30] = (mq.size() == 0);
        return v;
    endfunction

    function automatic logic [31:0] exp_cfg(input logic [2:0] en, input logic [2:0] err);
        logic [31:0] v = '0;
        v[2:0]  = en;
        v[3]    = mclr;
        v[4]    = (mq.size() != 0);
        v[5]    = (mq.size() != DEPTH);
        v[6]    = opp_empty;
        v[10:8] = err;
        return v;
    endfunction

    // driver: one cycle of stimulus plus reference model update
    task automatic drive(input logic we, input logic [1:0] wa, input logic [31:0] wd,
                         input logic re, input logic [1:0] ag, input string tag);
        int  pre;
        bit  flush_now;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = A_DATA; rd_agent = ag;
        pre = mq.size();
        flush_now = mclr || (we && wa == A_CFG && wd[3]);
        if (re) begin
            exp_data.push_back((ag == OWNER && pre > 0) ? mq[0] : 32'h0);
            exp_tag.push_back(tag);
            if (ag == OWNER && pre > 0 && !flush_now) void'(mq.pop_front());
        end
        if (we && wa == A_DATA && pre < DEPTH && !mclr) mq.push_back(wd);
        if (we && wa == A_CFG) begin
            if (wd[3]) mq.delete();
            mclr = wd[3];
        end
    endtask

    task automatic wr(input logic [1:0] wa, input logic [31:0] wd);
        drive(1'b1, wa, wd, 1'b0, OWNER, "");
    endtask

    task automatic rd(input logic [1:0] ag, input string tag);
        drive(1'b0, A_DATA, 32'h0, 1'b1, ag, tag);
    endtask

    task automatic check_reg(input logic [1:0] ra, input logic [31:0] exp, input string tag);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; rd_addr = ra; rd_agent = OWNER;
        #1 check(tag, rd_data, exp);
    endtask

    task automatic check_irq(input logic exp, input string tag);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        #1 check(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    // monitor: compare data reads against the expected queue
    always begin
        @(negedge clk);
        #1;
        if (rd_en && rd_addr == A_DATA) begin
            if (exp_data.size() == 0) check("monitor underrun", rd_data, 32'hxxxx_xxxx);
            else check(exp_tag.pop_front(), rd_data, exp_data.pop_front());
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        check_reg(A_STAT, exp_status(), "R2 reset status");
        check_reg(A_CFG, exp_cfg(3'b000, 3'b000), "R7 reset cfg");
        check_irq(1'b0, "R8 reset irq");

        // in-order delivery
        wr(A_DATA, 32'h1111_0001); wr(A_DATA, 32'h1111_0002); wr(A_DATA, 32'h1111_0003);
        rd(OWNER, "R1 order"); rd(OWNER, "R1 order"); rd(OWNER, "R1 order");

        // fill, then overflow
        for (int i = 0; i < DEPTH; i++) wr(A_DATA, 32'hA000_0000 + i);
        check_reg(A_STAT, exp_status(), "R2 full status");
        wr(A_DATA, 32'hDEAD_BEEF);
        check_reg(A_CFG, exp_cfg(3'b000, 3'b010), "R3 overflow flag");
        check_reg(A_STAT, 32'h8000_0000, "R3 still full");
        for (int i = 0; i < DEPTH; i++) rd(OWNER, "R3 drain without dropped word");

        // underflow, errors accumulate
        rd(OWNER, "R4 empty read zero");
        check_reg(A_CFG, exp_cfg(3'b000, 3'b110), "R6 sticky plus R4 underflow");
        wr(A_CFG, 32'h0);
        check_reg(A_CFG, exp_cfg(3'b000, 3'b000), "R6 cleared by cfg write");

        // non-owner read
        wr(A_DATA, 32'h5555_0001);
        rd(OTHER, "R5 non-owner gets zero");
        check_reg(A_STAT, 32'h0000_0000, "R5 word kept");
        wr(A_DATA, 32'h5555_0002);
        check_reg(A_CFG, exp_cfg(3'b000, 3'b001), "R5 flag sticky over write R6");
        rd(OWNER, "R5 owner gets kept word");
        rd(OWNER, "R5 second word");
        wr(A_CFG, 32'h0);

        // reserved bits
        wr(A_CFG, 32'hFFFF_FFF0);
        check_reg(A_CFG, exp_cfg(3'b000, 3'b000), "R7 reserved bits zero");

        // interrupt causes
        wr(A_CFG, 32'h1);
        check_irq(1'b0, "R8 has-data enabled, empty");
        wr(A_DATA, 32'h7777_0001);
        check_irq(1'b1, "R8 has-data raises");
        rd(OWNER, "R8 pop");
        check_irq(1'b0, "R8 has-data drops");
        wr(A_CFG, 32'h4);
        check_irq(1'b0, "R8 opp not empty");
        @(negedge clk); opp_empty = 1'b1;
        check_irq(1'b1, "R8 opp empty raises");
        check_reg(A_CFG, exp_cfg(3'b100, 3'b000), "R7 opp pending bit6");
        @(negedge clk); opp_empty = 1'b0;
        check_irq(1'b0, "R8 opp drops");
        wr(A_CFG, 32'h2);
        check_irq(1'b1, "R8 has-space");
        for (int i = 0; i < DEPTH; i++) wr(A_DATA, 32'hC000_0000 + i);
        check_irq(1'b0, "R8 full removes space");

        // clear control
        wr(A_CFG, 32'h8);
        check_reg(A_STAT, 32'h4000_0000, "R9 cleared");
        check_reg(A_CFG, exp_cfg(3'b000, 3'b000), "R9 clear bit visible");
        wr(A_DATA, 32'h9999_0001);
        check_reg(A_STAT, 32'h4000_0000, "R9 write dropped while clearing");
        wr(A_CFG, 32'h0);
        wr(A_DATA, 32'h9999_0002);
        rd(OWNER, "R9 resumes");

        // simultaneous write and read
        wr(A_DATA, 32'hE000_0000); wr(A_DATA, 32'hE000_0001);
        drive(1'b1, A_DATA, 32'hE000_0002, 1'b1, OWNER, "R10 concurrent read");
        check_reg(A_STAT, 32'h0000_0000, "R10 neither full nor empty");
        rd(OWNER, "R10 order"); rd(OWNER, "R10 order");
        check_reg(A_STAT, 32'h4000_0000, "R10 back to empty");

        check_irq(1'b0, "R8 idle end");
        check("scoreboard drained", exp_data.size(), 32'd0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule